// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block sits between a host bus and a battery-backed static RAM and decides, cycle by cycle, whether the memory may be reached. It receives two digitized supply-monitor levels. `pf_ok_raw` is high while the supply is above the power-fail threshold. `main_ok_raw` is high while the supply is above the lower battery switch-over threshold. Each level passes through a two-flop synchronizer and a deglitch counter before the sequencer acts on it.

The sequencer has five states. In NORMAL, host accesses pass straight through. DRAIN lets a write strobe that was already active finish, for at most `GRACE` cycles. PROTECTED deselects the memory. BATTERY also selects the battery as the power source. RECOVERING holds protection for `REC_CYC` cycles after the supply returns.

The transitions are:
- NORMAL→DRAIN: a failure is seen while a write strobe is active.
- NORMAL→PROTECTED: a failure is seen with no write in flight.
- DRAIN→PROTECTED: the strobe ends, or the grace window expires.
- PROTECTED→BATTERY: the switch-over level falls.
- BATTERY→PROTECTED: the switch-over level returns.
- PROTECTED→RECOVERING: the power-fail level returns.
- RECOVERING→PROTECTED: the power-fail level falls again.
- RECOVERING→BATTERY: the switch-over level falls.
- RECOVERING→NORMAL: the recovery count completes.

A two-bit status output reports NORMAL, PROTECTED (this code also covers DRAIN), BATTERY or RECOVERING.

Top module: `pfwp_supervisor`

## Requirements
- R1: In NORMAL, `mem_cs_n`, `mem_we_n`, `mem_oe_n`, `mem_addr` and `mem_wdata` equal the corresponding host inputs in the same cycle.
- R2: In PROTECTED, BATTERY and RECOVERING, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are all 1, whatever the host drives.
- R3: While the memory is deselected, `host_rdata_en` is 0, `host_rdata` is 0, and `mem_addr` and `mem_wdata` are 0, so host address and data inputs have no effect.
- R4: When the filtered switch-over level is low in PROTECTED, the next state is BATTERY and `pwr_sel_batt` is 1.
- R5: When the filtered switch-over level returns in BATTERY, the next state is PROTECTED and `pwr_sel_batt` is 0.
- R6: After the power-fail level returns, the status stays RECOVERING for exactly `REC_CYC` cycles with writes blocked, and then becomes NORMAL.
- R7: A level change is accepted only after `DEGLITCH` consecutive matching synchronized samples, so the status changes `DEGLITCH`+3 clock edges after a raw change, and a pulse of `DEGLITCH`-1 cycles has no effect.
- R8: A power-fail drop during RECOVERING returns the sequencer to PROTECTED, and the next recovery lasts a full `REC_CYC` cycles.
- R9: `host_rdata_en` is 1 only in NORMAL with `host_cs_n`=0, `host_oe_n`=0 and `host_we_n`=1. When chip select and write enable are both low, the read data stays disabled.
- R10: A failure seen during an active write (`host_cs_n`=0, `host_we_n`=0) enters DRAIN. DRAIN reports the PROTECTED code, passes chip select, write enable, address and write data, and holds `mem_oe_n` at 1.
- R11: DRAIN lasts at most `GRACE` cycles. After that, `mem_we_n` is forced to 1 even if the host keeps writing.
- R12: `state_code` encodes 0 = NORMAL, 1 = PROTECTED or DRAIN, 2 = BATTERY, 3 = RECOVERING. Reset enters NORMAL with `pwr_sel_batt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pf_ok_raw | input | 1 | Supply above power-fail threshold (asynchronous) |
| main_ok_raw | input | 1 | Supply above switch-over threshold (asynchronous) |
| host_cs_n | input | 1 | Host chip select, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_addr | input | AW | Host address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Read data to host, 0 when disabled |
| host_rdata_en | output | 1 | Read data drive enable (0 = high impedance) |
| mem_cs_n | output | 1 | Gated chip select to RAM |
| mem_we_n | output | 1 | Gated write enable to RAM |
| mem_oe_n | output | 1 | Gated output enable to RAM |
| mem_addr | output | AW | Gated address to RAM |
| mem_wdata | output | DW | Gated write data to RAM |
| mem_rdata | input | DW | Read data from RAM |
| pwr_sel_batt | output | 1 | 1 selects the battery supply |
| state_code | output | 2 | Status code |

## Verification
The assertions assume the switch-over level only falls while the power-fail level is already low, because the two thresholds are ordered. They also assume that the raw levels and the host strobes change away from the clock edge. The stimulus drives every input one time unit after a rising edge. It lowers the switch-over input only inside a protected interval, and it keeps every deliberate glitch shorter than the deglitch count, so each transition the checks expect follows from a settled filtered level.

// File: rtl/pfwp_pkg.sv
package pfwp_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL,
        ST_DRAIN,
        ST_PROT,
        ST_BATT,
        ST_RECOV
    } sup_state_e;

    localparam logic [1:0] CODE_NORMAL = 2'd0;
    localparam logic [1:0] CODE_PROT   = 2'd1;
    localparam logic [1:0] CODE_BATT   = 2'd2;
    localparam logic [1:0] CODE_RECOV  = 2'd3;

    function automatic logic [1:0] code_of(sup_state_e s);
        logic [1:0] c;
        unique case (s)
            ST_NORMAL: c = CODE_NORMAL;
            ST_DRAIN:  c = CODE_PROT;
            ST_PROT:   c = CODE_PROT;
            ST_BATT:   c = CODE_BATT;
            ST_RECOV:  c = CODE_RECOV;
            default:   c = CODE_PROT;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pfwp_deglitch.sv
module pfwp_deglitch #(
    parameter int   DEGLITCH = 4,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(DEGLITCH + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_cnt;
    logic          stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q   <= {2{RST_VAL}};
            run_cnt  <= '0;
            stable_q <= RST_VAL;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (sync_q[1] == stable_q) begin
                run_cnt <= '0;
            end else if (run_cnt == CW'(DEGLITCH - 1)) begin
                stable_q <= sync_q[1];
                run_cnt  <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign clean = stable_q;

    // R7
    accept_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stable_q) |-> ($past(sync_q[1]) == stable_q));

    // R7
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt < CW'(DEGLITCH));

endmodule

// File: rtl/pfwp_fsm.sv
module pfwp_fsm
    import pfwp_pkg::*;
#(
    parameter int REC_CYC = 64,
    parameter int GRACE   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pf_ok,
    input  logic       main_ok,
    input  logic       wr_active,
    output logic       pass,
    output logic       drain,
    output logic       batt_sel,
    output logic [1:0] status_code
);
    localparam int RW = $clog2(REC_CYC + 1);
    localparam int GW = $clog2(GRACE + 1);

    sup_state_e    state_q, state_d;
    logic [RW-1:0] rec_cnt;
    logic [GW-1:0] grace_cnt;
    logic          rec_done, grace_done;

    assign rec_done   = (rec_cnt == RW'(REC_CYC - 1));
    assign grace_done = (grace_cnt == GW'(GRACE - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL: begin
                if (!pf_ok || !main_ok)
                    state_d = wr_active ? ST_DRAIN : ST_PROT;
            end
            ST_DRAIN: begin
                if (!wr_active || grace_done)
                    state_d = ST_PROT;
            end
            ST_PROT: begin
                if (!main_ok)
                    state_d = ST_BATT;
                else if (pf_ok)
                    state_d = ST_RECOV;
            end
            ST_BATT: begin
                if (main_ok)
                    state_d = ST_PROT;
            end
            ST_RECOV: begin
                if (!main_ok)
                    state_d = ST_BATT;
                else if (!pf_ok)
                    state_d = ST_PROT;
                else if (rec_done)
                    state_d = ST_NORMAL;
            end
            default: state_d = ST_PROT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_NORMAL;
            rec_cnt   <= '0;
            grace_cnt <= '0;
        end else begin
            state_q   <= state_d;
            rec_cnt   <= (state_q == ST_RECOV)  ? rec_cnt + 1'b1   : '0;
            grace_cnt <= (state_q == ST_DRAIN) ? grace_cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        pass        = (state_q == ST_NORMAL);
        drain       = (state_q == ST_DRAIN);
        batt_sel    = (state_q == ST_BATT);
        status_code = code_of(state_q);
    end

    // R4
    batt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROT && !main_ok) |=> (state_q == ST_BATT));

    // R5
    batt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BATT && main_ok) |=> (state_q == ST_PROT));

    // R6
    rec_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORMAL && $past(state_q) == ST_RECOV)
            |-> ($past(rec_cnt) == RW'(REC_CYC - 1)));

    // R8
    rec_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOV && !pf_ok && main_ok) |=> (state_q == ST_PROT));

    // R11
    grace_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> (grace_cnt < GW'(GRACE)));

endmodule

// File: rtl/pfwp_gate.sv
module pfwp_gate #(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pass,
    input  logic          drain,
    input  logic          host_cs_n,
    input  logic          host_we_n,
    input  logic          host_oe_n,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_rdata_en,
    output logic          mem_cs_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);
    always_comb begin
        mem_cs_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_addr  = '0;
        mem_wdata = '0;
        if (pass) begin
            mem_cs_n  = host_cs_n;
            mem_we_n  = host_we_n;
            mem_oe_n  = host_oe_n;
            mem_addr  = host_addr;
            mem_wdata = host_wdata;
        end else if (drain) begin
            mem_cs_n  = host_cs_n;
            mem_we_n  = host_we_n;
            mem_addr  = host_addr;
            mem_wdata = host_wdata;
        end
        host_rdata_en = pass && !host_cs_n && !host_oe_n && host_we_n;
        host_rdata    = host_rdata_en ? mem_rdata : '0;
    end

    // R2
    no_write_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass && !drain) |-> (mem_we_n && mem_cs_n && mem_oe_n));

    // R9
    rd_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata_en |-> (host_we_n && !mem_cs_n));

    // R10
    drain_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drain |-> (mem_oe_n && !host_rdata_en));

endmodule

// File: rtl/pfwp_supervisor.sv
module pfwp_supervisor #(
    parameter int AW       = 19,
    parameter int DW       = 8,
    parameter int DEGLITCH = 4,
    parameter int REC_CYC  = 64,
    parameter int GRACE    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pf_ok_raw,
    input  logic          main_ok_raw,
    input  logic          host_cs_n,
    input  logic          host_we_n,
    input  logic          host_oe_n,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_rdata_en,
    output logic          mem_cs_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          pwr_sel_batt,
    output logic [1:0]    state_code
);
    localparam int NMON = 2;

    logic [NMON-1:0] raw_vec, clean_vec;
    logic            pass, drain, wr_active;

    assign raw_vec = {main_ok_raw, pf_ok_raw};

    for (genvar g = 0; g < NMON; g++) begin : g_mon
        pfwp_deglitch #(
            .DEGLITCH (DEGLITCH),
            .RST_VAL  (1'b1)
        ) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_vec[g]),
            .clean (clean_vec[g])
        );
    end

    assign wr_active = !host_cs_n && !host_we_n;

    pfwp_fsm #(
        .REC_CYC (REC_CYC),
        .GRACE   (GRACE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pf_ok       (clean_vec[0]),
        .main_ok     (clean_vec[1]),
        .wr_active   (wr_active),
        .pass        (pass),
        .drain       (drain),
        .batt_sel    (pwr_sel_batt),
        .status_code (state_code)
    );

    pfwp_gate #(
        .AW (AW),
        .DW (DW)
    ) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .pass          (pass),
        .drain         (drain),
        .host_cs_n     (host_cs_n),
        .host_we_n     (host_we_n),
        .host_oe_n     (host_oe_n),
        .host_addr     (host_addr),
        .host_wdata    (host_wdata),
        .mem_rdata     (mem_rdata),
        .host_rdata    (host_rdata),
        .host_rdata_en (host_rdata_en),
        .mem_cs_n      (mem_cs_n),
        .mem_we_n      (mem_we_n),
        .mem_oe_n      (mem_oe_n),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata)
    );

    // R12
    batt_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_sel_batt |-> (state_code == 2'd2));

endmodule

// File: tb/test_pfwp_supervisor.sv
module test_pfwp_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 8;
    localparam int DG = 4;
    localparam int REC = 20;
    localparam int GR = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pf_ok_raw = 1'b1, main_ok_raw = 1'b1;
    logic          host_cs_n = 1'b1, host_we_n = 1'b1, host_oe_n = 1'b1;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] mem_rdata = 8'hA5;
    logic [DW-1:0] host_rdata, mem_wdata;
    logic [AW-1:0] mem_addr;
    logic          host_rdata_en, mem_cs_n, mem_we_n, mem_oe_n, pwr_sel_batt;
    logic [1:0]    state_code;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfwp_supervisor #(
        .AW(AW), .DW(DW), .DEGLITCH(DG), .REC_CYC(REC), .GRACE(GR)
    ) i_pfwp_supervisor (
        .clk(clk), .rst_n(rst_n), .pf_ok_raw(pf_ok_raw), .main_ok_raw(main_ok_raw),
        .host_cs_n(host_cs_n), .host_we_n(host_we_n), .host_oe_n(host_oe_n),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rdata_en(host_rdata_en),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pwr_sel_batt(pwr_sel_batt), .state_code(state_code)
    );

    typedef struct packed {
        logic [1:0]    code;
        logic          cs_n, we_n, oe_n, rd_en, batt;
        logic [DW-1:0] rdata, wdata;
        logic [AW-1:0] addr;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    exp_t  mon_e, mon_a;
    string mon_t;

    // monitor: pops one expected item per falling edge and compares
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            mon_a = '{state_code, mem_cs_n, mem_we_n, mem_oe_n, host_rdata_en,
                      pwr_sel_batt, host_rdata, mem_wdata, mem_addr};
            checks++;
            if (mon_a !== mon_e) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", mon_t, mon_a, mon_e);
            end
        end
    end

    task automatic expect_out(string tag, logic [1:0] code, logic cs_n, logic we_n,
                              logic oe_n, logic rd_en, logic batt, logic [DW-1:0] rdata,
                              logic [DW-1:0] wdata, logic [AW-1:0] addr);
        exp_t e;
        e = '{code, cs_n, we_n, oe_n, rd_en, batt, rdata, wdata, addr};
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        #1;
    endtask

    task automatic expect_blocked(string tag, logic [1:0] code, logic batt);
        expect_out(tag, code, 1'b1, 1'b1, 1'b1, 1'b0, batt, '0, '0, '0);
    endtask

    task automatic check_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        host_cs_n = 1'b1; host_we_n = 1'b1; host_oe_n = 1'b1;
        host_addr = '0;   host_wdata = '0;
    endtask

    task automatic host_write(logic [AW-1:0] a, logic [DW-1:0] d);
        host_cs_n = 1'b0; host_we_n = 1'b0; host_oe_n = 1'b1;
        host_addr = a;    host_wdata = d;
    endtask

    task automatic wait_code(string tag, logic [1:0] c, output int edges);
        edges = 0;
        forever begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (state_code == c) break;
            if (edges >= 200) begin
                check_eq({tag, " state reached"}, int'(state_code), int'(c));
                break;
            end
        end
        #1;
    endtask

    task automatic count_code(logic [1:0] c, output int n);
        n = 1;
        forever begin
            @(posedge clk);
            @(negedge clk);
            if (state_code == c && n < 500) n++;
            else break;
        end
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int e;
        int n;
        idle();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R12 reset state
        expect_out("R12 reset", 2'd0, 1, 1, 1, 0, 0, '0, '0, '0);

        // R1 read pass-through
        step(); host_cs_n = 0; host_oe_n = 0; host_addr = 12'h123;
        expect_out("R1 read", 2'd0, 0, 1, 0, 1, 0, 8'hA5, '0, 12'h123);

        // R1 and R9 write pass-through, read data stays disabled
        step(); host_write(12'h321, 8'h3C); host_oe_n = 0;
        expect_out("R9 write with oe", 2'd0, 0, 0, 0, 0, 0, '0, 8'h3C, 12'h321);

        // R7 short glitch ignored
        step(); idle(); pf_ok_raw = 0;
        repeat (DG - 1) step();
        pf_ok_raw = 1;
        repeat (10) step();
        expect_out("R7 glitch ignored", 2'd0, 1, 1, 1, 0, 0, '0, '0, '0);

        // R7 acceptance latency, R2 and R3 blocking
        step(); pf_ok_raw = 0;
        wait_code("R7", 2'd1, e);
        check_eq("R7 latency", e, DG + 3);
        step(); host_write(12'h055, 8'h66); host_oe_n = 0;
        expect_blocked("R2 R3 protected write", 2'd1, 0);

        // R4 and R5 battery switch
        idle(); main_ok_raw = 0;
        wait_code("R4", 2'd2, e);
        expect_blocked("R4 battery", 2'd2, 1);
        main_ok_raw = 1;
        wait_code("R5", 2'd1, e);
        expect_blocked("R5 external", 2'd1, 0);

        // R6 recovery length
        pf_ok_raw = 1;
        wait_code("R6", 2'd3, e);
        count_code(2'd3, n);
        check_eq("R6 recovery cycles", n, REC);
        step(); host_cs_n = 0; host_oe_n = 0; host_addr = 12'h009;
        expect_out("R1 after recovery", 2'd0, 0, 1, 0, 1, 0, 8'hA5, '0, 12'h009);

        // R8 restart of recovery
        idle(); pf_ok_raw = 0;
        wait_code("R8 fail", 2'd1, e);
        pf_ok_raw = 1;
        wait_code("R8 recov", 2'd3, e);
        step(); host_write(12'h0AA, 8'h5A);
        expect_blocked("R6 write in recovery", 2'd3, 0);
        idle();
        repeat (4) step();
        pf_ok_raw = 0;
        repeat (DG + 2) step();
        pf_ok_raw = 1;
        wait_code("R8 abort", 2'd1, e);
        check_eq("R8 abort to protected", int'(state_code), 1);
        wait_code("R8 rerecov", 2'd3, e);
        count_code(2'd3, n);
        check_eq("R8 full recovery again", n, REC);

        // R10 drain of in-flight write
        step(); host_write(12'h077, 8'h11); pf_ok_raw = 0;
        wait_code("R10", 2'd1, e);
        expect_out("R10 drain passes write", 2'd1, 0, 0, 1, 0, 0, '0, 8'h11, 12'h077);
        step(); host_cs_n = 1; host_we_n = 1;
        expect_out("R10 strobe end", 2'd1, 1, 1, 1, 0, 0, '0, 8'h11, 12'h077);
        step(); host_write(12'h077, 8'h11);
        expect_blocked("R2 after drain", 2'd1, 0);
        idle(); pf_ok_raw = 1;
        wait_code("R10 recov", 2'd3, e);
        wait_code("R10 normal", 2'd0, e);

        // R11 cut-off of a held strobe
        step(); host_write(12'h044, 8'h22); pf_ok_raw = 0;
        wait_code("R11", 2'd1, e);
        n = 1;
        forever begin
            @(posedge clk);
            @(negedge clk);
            if (state_code == 2'd1 && !mem_we_n && n < 500) n++;
            else break;
        end
        #1;
        check_eq("R11 grace cycles", n, GR);
        expect_blocked("R11 strobe cut", 2'd1, 0);
        idle(); pf_ok_raw = 1;
        wait_code("R11 recov", 2'd3, e);
        wait_code("R11 normal", 2'd0, e);
        expect_out("R12 normal code", 2'd0, 1, 1, 1, 0, 0, '0, '0, '0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule